// File: doc/BRIEF.md
# Transmit DMA End-of-Transfer Handler

This block sits on the send side of a USB-style device controller. It lies between an external DMA engine and the packet transmit buffer. The DMA engine writes bytes into the buffer one strobe at a time, and the block keeps a running count of those bytes modulo the programmed maximum packet size. A full packet is dispatched by the packet engine on its own, so the count wraps back to zero at each packet boundary.

When the DMA engine raises its end-of-transfer strobe, the block looks at the remaining count. If some bytes are left over, it issues a one-cycle commit pulse, and the leftover length travels with it, so that the short buffer becomes eligible to send. The effect is the same as software marking the buffer valid. If the transfer stopped exactly on a packet boundary, nothing is committed. In that case, when appending is enabled, the block raises a request for one zero-length packet and holds it until the packet engine acknowledges it. The strobe acts only while the selected pipe is set to the send direction.

Top module: `dma_txend_ctl`

## Requirements
- R1: After reset, `commit` and `zlp_req` are low and the byte count is zero.
- R2: Each cycle with `wr_stb` high adds one byte to the count. When the count reaches `mps` (legal range 8 to 1024), it wraps to zero, so `commit_len` is always less than `mps`.
- R3: An end strobe with a nonzero count gives a `commit` pulse one cycle later. The pulse lasts a single cycle, and `commit_len` equals the count.
- R4: An end strobe with a zero count gives no `commit` pulse.
- R5: An end strobe with a zero count, `zlp_en` high and `dir_tx` high raises `zlp_req` one cycle later. `zlp_req` then stays high until a cycle in which `zlp_ack` is high, and it is low in the cycle after that.
- R6: An end strobe with a nonzero count never raises `zlp_req`, even with `zlp_en` high.
- R7: With `zlp_en` low, no end strobe raises `zlp_req`.
- R8: While `dir_tx` is low, `end_in` is ignored: no commit and no request. Bytes written meanwhile are still counted.
- R9: After a commit the count restarts from zero.
- R10: At most one zero-length request is raised per event. An end strobe that arrives while a request is pending, or in the cycle it is acknowledged, raises no further request.
- R11: An acknowledge of a pending request clears the count. Bytes written while the request was pending are discarded.
- R12: A byte written in the same cycle as the end strobe counts toward that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_tx | input | 1 | Selected pipe is in the send direction |
| zlp_en | input | 1 | Enable zero-length packet appending |
| mps | input | CNT_W | Maximum packet size in bytes |
| wr_stb | input | 1 | One byte written to the buffer this cycle |
| end_in | input | 1 | End-of-transfer strobe from the DMA side |
| zlp_ack | input | 1 | Packet engine has taken the zero-length request |
| commit | output | 1 | One-cycle pulse: short buffer is ready to send |
| commit_len | output | CNT_W | Bytes in the committed short buffer |
| zlp_req | output | 1 | Zero-length packet request, held until acknowledged |

## Verification
For several small packet sizes, every transfer length from zero up to a little over two packets is run, once with appending off and once with it on. Lengths that leave a remainder test the commit path and its length. Exact multiples, zero included, separate the zero-length request from a commit. Comparing the two enable settings shows that the enable gates only the request. Directed sequences cover the remaining behaviour: an end strobe in the receive direction, a second strobe while a request is pending, and bytes written before an acknowledge. These show that the direction gate, single-request rule and counter clearing act on their own.

// File: rtl/dma_txend_ctl.sv
module dma_txend_ctl #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_tx,
  input  logic             zlp_en,
  input  logic [CNT_W-1:0] mps,
  input  logic             wr_stb,
  input  logic             end_in,
  input  logic             zlp_ack,
  output logic             commit,
  output logic [CNT_W-1:0] commit_len,
  output logic             zlp_req
);

  logic [CNT_W-1:0] cnt;

  wire             ack_hit   = zlp_req & zlp_ack;
  wire [CNT_W-1:0] base      = ack_hit ? '0 : cnt;
  wire [CNT_W-1:0] inc       = base + 1'b1;
  wire [CNT_W-1:0] nxt       = wr_stb ? ((inc >= mps) ? '0 : inc) : base;
  wire             ev        = end_in & dir_tx;
  wire             do_commit = ev & (nxt != '0);
  wire             do_zlp    = ev & (nxt == '0) & zlp_en & ~zlp_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      commit     <= 1'b0;
      commit_len <= '0;
      zlp_req    <= 1'b0;
    end else begin
      cnt        <= do_commit ? '0 : nxt;
      commit     <= do_commit;
      commit_len <= do_commit ? nxt : '0;
      zlp_req    <= do_zlp | (zlp_req & ~zlp_ack);
    end
  end

endmodule

module dma_txend_ctl_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_tx,
  input logic             zlp_en,
  input logic [CNT_W-1:0] mps,
  input logic             end_in,
  input logic             zlp_ack,
  input logic             commit,
  input logic [CNT_W-1:0] commit_len,
  input logic             zlp_req
);

  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> commit_len != '0);

  p_len_below_mps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> commit_len < mps);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_req && !zlp_ack |=> zlp_req);

  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_req && zlp_ack |=> !zlp_req);

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && $rose(zlp_req)));

  p_no_req_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !zlp_en |=> !$rose(zlp_req));

  p_rx_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_tx |=> !commit && !$rose(zlp_req));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !end_in |=> !commit && !$rose(zlp_req));

endmodule

bind dma_txend_ctl dma_txend_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .zlp_en(zlp_en), .mps(mps),
  .end_in(end_in), .zlp_ack(zlp_ack), .commit(commit),
  .commit_len(commit_len), .zlp_req(zlp_req)
);

// File: tb/tb_dma_txend_ctl.sv
module tb_dma_txend_ctl;
  localparam int CNT_W = 11;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_tx = 1'b1, zlp_en = 1'b0, wr_stb = 1'b0, end_in = 1'b0, zlp_ack = 1'b0;
  logic [CNT_W-1:0] mps = 11'd8;
  logic commit, zlp_req;
  logic [CNT_W-1:0] commit_len;

  int tests = 0, fails = 0;
  bit done = 0;

  dma_txend_ctl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .zlp_en(zlp_en), .mps(mps),
    .wr_stb(wr_stb), .end_in(end_in), .zlp_ack(zlp_ack),
    .commit(commit), .commit_len(commit_len), .zlp_req(zlp_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic write_bytes(input int n, input bit with_end);
    for (int i = 0; i < n; i++) begin
      wr_stb = 1'b1;
      end_in = with_end && (i == n - 1);
      step();
    end
    wr_stb = 1'b0;
    end_in = 1'b0;
  endtask

  task automatic end_only;
    end_in = 1'b1;
    step();
    end_in = 1'b0;
  endtask

  task automatic ack_req;
    zlp_ack = 1'b1;
    step();
    zlp_ack = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7 R9 R12: one full transfer and its expected outcome
  task automatic run_xfer(input int m, input int len, input bit en);
    int r;
    bit ec, ez;
    mps = CNT_W'(m);
    zlp_en = en;
    dir_tx = 1'b1;
    r = len % m;
    ec = (r != 0);
    ez = (r == 0) && en;
    if (len == 0) end_only();
    else write_bytes(len, 1'b1);
    check(int'(commit), int'(ec), ec ? "R3 commit" : "R4 no commit");
    if (ec) check(int'(commit_len), r, "R2 R12 commit_len");
    check(int'(zlp_req), int'(ez), ez ? "R5 zlp raised" : (en ? "R6 no zlp" : "R7 no zlp"));
    step();
    check(int'(commit), 0, "R3 single pulse");
    if (ez) begin
      check(int'(zlp_req), 1, "R5 zlp held");
      ack_req();
      check(int'(zlp_req), 0, "R5 zlp cleared");
    end
  endtask

  initial begin
    repeat (3) step();
    check(int'(commit), 0, "R1 commit");
    check(int'(zlp_req), 0, "R1 zlp_req");
    rst_n = 1'b1;
    step();
    write_bytes(3, 1'b1);
    check(int'(commit_len), 3, "R1 count starts at zero");
    step();

    for (int m = 8; m <= 12; m++)
      for (int en = 0; en < 2; en++)
        for (int len = 0; len <= 2 * m + 2; len++)
          run_xfer(m, len, en[0]);

    // R9: after a commit, the next transfer counts from zero
    mps = 11'd8; zlp_en = 1'b0;
    write_bytes(5, 1'b1);
    step();
    write_bytes(2, 1'b1);
    check(int'(commit_len), 2, "R9 restart");
    step();

    // R8: receive direction ignores end but keeps counting
    dir_tx = 1'b0; zlp_en = 1'b1;
    write_bytes(3, 1'b1);
    check(int'(commit), 0, "R8 no commit");
    end_only();
    check(int'(zlp_req), 0, "R8 no zlp");
    check(int'(commit), 0, "R8 no commit 2");
    dir_tx = 1'b1;
    end_only();
    check(int'(commit), 1, "R8 later commit");
    check(int'(commit_len), 3, "R8 bytes kept");
    step();

    // R10: second end while pending raises nothing extra
    end_only();
    check(int'(zlp_req), 1, "R10 first req");
    end_only();
    check(int'(zlp_req), 1, "R10 still one req");
    zlp_ack = 1'b1; end_in = 1'b1;
    step();
    zlp_ack = 1'b0; end_in = 1'b0;
    check(int'(zlp_req), 0, "R10 no re-raise on ack cycle");
    step();
    check(int'(zlp_req), 0, "R10 stays low");

    // R11: acknowledge clears bytes written while pending
    end_only();
    check(int'(zlp_req), 1, "R11 req");
    write_bytes(3, 1'b0);
    ack_req();
    write_bytes(2, 1'b1);
    check(int'(commit_len), 2, "R11 count cleared");
    step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule